// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write an external 8K x 8 asynchronous static RAM that has a pair of chip selects (one active low, one active high), an active-low output enable, an active-low write strobe and a shared data bus. The client presents one request at a time. Each request carries a 13-bit address, a direction flag and, for a write, an 8-bit data byte. The controller then plays out the RAM pin sequence over as many clock cycles as the nanosecond timing of the part demands.

Every timing figure is a nanosecond parameter. The clock period is a parameter as well. Each phase length is the ratio of the two rounded up, and never less than one cycle. All RAM-facing outputs come straight from flops. The data pad is left to the chip top: the block gives the outgoing byte, a drive enable, and takes the incoming byte. A read hands back its byte with a one-cycle valid strobe. A write reports completion with a one-cycle done strobe.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, the select pair is inactive (active-low select 1, active-high select 0), output enable and write strobe are 1, the data drive enable is 0, ready is 1, and the valid and done strobes are 0.
- R2: A request is taken only on a clock edge where ready is 1 and the request valid input is 1. Ready drops in the next cycle. Request inputs presented while ready is 0 have no effect on the RAM pins or on the result of the operation in progress.
- R3: A read holds the RAM selected, the output enable at 0 and the write strobe at 1, with the request address on the address pins, for RD_CYC = max(ceil(T_AA/CLK), ceil(T_OE/CLK)) cycles. This is 8 cycles with defaults (10 ns clock, 80 ns access, 40 ns enable access).
- R4: Read data is sampled from the incoming bus on the last access cycle. The valid strobe is 1 for exactly the one cycle that follows, with the sampled byte on the read data output.
- R5: After a read, the RAM is deselected with output enable 1 for HZ_CYC = ceil(T_HZ/CLK) cycles (3 with defaults) before ready returns. The output enable is never 0 while the data drive enable is 1.
- R6: A write holds the RAM selected, the write strobe at 0 and the output enable at 1 for WP_CYC = max of the rounded write pulse, address-to-end-of-write and data-to-end-of-write times (7 with defaults). The drive enable is 1 and the request byte is on the outgoing data exactly in those cycles.
- R7: After a write, the RAM is deselected for max(1, ceil(T_CYC/CLK) - WP_CYC) cycles (1 with defaults). The done strobe is then 1 for one cycle, which is also the first cycle with ready at 1.
- R8: The output enable and the write strobe are never 0 in the same cycle.
- R9: Each phase loads a cycle count of at least one, and the address pins do not change while an operation is in progress.
- R10: A byte written to an address is returned by a later read of that address, at the lowest and highest addresses and in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle, a request may be taken |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read byte |
| wr_done | output | 1 | One-cycle write completion strobe |
| ram_addr | output | 13 | RAM address pins |
| ram_sel_n | output | 1 | Active-low RAM select |
| ram_sel | output | 1 | Active-high RAM select |
| ram_rd_en_n | output | 1 | Active-low RAM output enable |
| ram_wr_n | output | 1 | Active-low RAM write strobe |
| ram_dq_out | output | 8 | Byte to drive onto the RAM bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM bus pad |
| ram_dq_in | input | 8 | Byte received from the RAM bus |

## Verification
Some properties are checked on every cycle: output enable and write strobe are never low together, the bus is never driven while the output enable is low, strobes are one cycle wide, a taken request drops ready at once, and the address stays put while an operation is in progress. The exact phase lengths cannot be checked that way, nor the sampling point of read data, nor the fact that a request during a busy period is ignored. Those show only in the bench scenarios, where a cycle model of the RAM returns a byte only once the access time has elapsed, flags bus contention, and keeps its own copy of memory to compare against.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_RHZ,
    PH_WR,
    PH_WREC
  } phase_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R9: every phase length is at least one cycle
  a_r9_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW       = 4,
  parameter int RD_CYC   = 8,
  parameter int HZ_CYC   = 3,
  parameter int WP_CYC   = 7,
  parameter int WREC_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          last,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          ready,
  output logic          capture,
  output logic          sel_n,
  output logic          sel,
  output logic          rd_en_n,
  output logic          wr_n,
  output logic          dq_oe,
  output logic          done
);

  localparam logic [CW-1:0] RD_L   = CW'(RD_CYC);
  localparam logic [CW-1:0] HZ_L   = CW'(HZ_CYC);
  localparam logic [CW-1:0] WP_L   = CW'(WP_CYC);
  localparam logic [CW-1:0] WREC_L = CW'(WREC_CYC);

  phase_e ph_q, ph_d;
  logic   sel_n_q, sel_q, rd_en_n_q, wr_n_q, dq_oe_q, done_q;
  logic   active_d;

  // next-state logic
  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_d     = req_write ? PH_WR : PH_RD;
        load     = 1'b1;
        load_val = req_write ? WP_L : RD_L;
      end
      PH_RD: if (last) begin
        ph_d     = PH_RHZ;
        load     = 1'b1;
        load_val = HZ_L;
      end
      PH_RHZ: if (last) ph_d = PH_IDLE;
      PH_WR: if (last) begin
        ph_d     = PH_WREC;
        load     = 1'b1;
        load_val = WREC_L;
      end
      PH_WREC: if (last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign active_d = (ph_d == PH_RD) || (ph_d == PH_WR);

  // registers: pins follow the phase being entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      sel_n_q   <= 1'b1;
      sel_q     <= 1'b0;
      rd_en_n_q <= 1'b1;
      wr_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      sel_n_q   <= !active_d;
      sel_q     <= active_d;
      rd_en_n_q <= (ph_d != PH_RD);
      wr_n_q    <= (ph_d != PH_WR);
      dq_oe_q   <= (ph_d == PH_WR);
      done_q    <= (ph_q == PH_WREC) && last;
    end
  end

  assign ready   = (ph_q == PH_IDLE);
  assign capture = (ph_q == PH_RD) && last;
  assign sel_n   = sel_n_q;
  assign sel     = sel_q;
  assign rd_en_n = rd_en_n_q;
  assign wr_n    = wr_n_q;
  assign dq_oe   = dq_oe_q;
  assign done    = done_q;

  a_r8_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_en_n_q && !wr_n_q));

  a_r5_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> rd_en_n_q);

  a_r6_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_q) |-> (!sel_n_q && sel_q));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ready);

  a_r2_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (sel_n_q && rd_en_n_q && wr_n_q && !dq_oe_q));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d, rdat_q, rdat_d;
  logic          rv_q;

  always_comb begin
    addr_d = accept  ? req_addr  : addr_q;
    wd_d   = accept  ? req_wdata : wd_q;
    rdat_d = capture ? dq_in     : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      rdat_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rdat_q <= rdat_d;
      rv_q   <= capture;
    end
  end

  assign addr     = addr_q;
  assign dq_out   = wd_q;
  assign rd_data  = rdat_q;
  assign rd_valid = rv_q;

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));

  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdat_q));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 80,
  parameter int T_OE_NS   = 40,
  parameter int T_HZ_NS   = 30,
  parameter int T_WP_NS   = 60,
  parameter int T_AW_NS   = 70,
  parameter int T_DW_NS   = 40,
  parameter int T_CYC_NS  = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_done,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_rd_en_n,
  output logic          ram_wr_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int RD_CYC   = int'(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int HZ_CYC   = int'(ns2cyc(T_HZ_NS, CLK_NS));
  localparam int WP_CYC   = int'(umax(ns2cyc(T_WP_NS, CLK_NS),
                                      umax(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS))));
  localparam int CYC_CYC  = int'(ns2cyc(T_CYC_NS, CLK_NS));
  localparam int WREC_CYC = (CYC_CYC > WP_CYC) ? (CYC_CYC - WP_CYC) : 1;
  localparam int MAX_CYC  = int'(umax(umax(RD_CYC, HZ_CYC), umax(WP_CYC, WREC_CYC)));
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic          rst_meta, rst_sync;
  logic          load, last, capture, accept;
  logic [CW-1:0] load_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign accept = ready && req_valid;

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  asram_seq #(
    .CW       (CW),
    .RD_CYC   (RD_CYC),
    .HZ_CYC   (HZ_CYC),
    .WP_CYC   (WP_CYC),
    .WREC_CYC (WREC_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .req_valid (req_valid),
    .req_write (req_write),
    .last      (last),
    .load      (load),
    .load_val  (load_val),
    .ready     (ready),
    .capture   (capture),
    .sel_n     (ram_sel_n),
    .sel       (ram_sel),
    .rd_en_n   (ram_rd_en_n),
    .wr_n      (ram_wr_n),
    .dq_oe     (ram_dq_oe),
    .done      (wr_done)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (ram_dq_in),
    .addr      (ram_addr),
    .dq_out    (ram_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  // phase lengths from the requirements at a 10 ns clock
  localparam int RD_C   = 8;  // R3: max(80/10, 40/10)
  localparam int HZ_C   = 3;  // R5: 30/10 rounded up
  localparam int WP_C   = 7;  // R6: max(60, 70, 40)/10
  localparam int WREC_C = 1;  // R7: max(1, 8 - 7)
  localparam int AA_C   = 8;  // RAM model: 80 ns access

  typedef struct {
    logic [7:0]  ctl;   // {sel_n, sel, rd_en_n, wr_n, dq_oe, ready, rd_valid, wr_done}
    logic        chk_addr;
    logic [12:0] addr;
    logic        chk_dq;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rd_valid, wr_done;
  logic [7:0]  rd_data;
  logic [12:0] ram_addr;
  logic        ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_n, ram_dq_oe;
  logic [7:0]  ram_dq_out, ram_dq_in;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [7:0] mem [0:8191];
  logic [7:0] shadow [0:8191];
  int rd_cnt = 0;

  always #5 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_done(wr_done), .ram_addr(ram_addr), .ram_sel_n(ram_sel_n),
    .ram_sel(ram_sel), .ram_rd_en_n(ram_rd_en_n), .ram_wr_n(ram_wr_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // ---------------- RAM cycle model ----------------
  wire selected = !ram_sel_n && ram_sel;
  wire ram_reads = selected && !ram_rd_en_n && ram_wr_n;
  assign ram_dq_in = (ram_reads && rd_cnt >= AA_C - 1) ? mem[ram_addr] : 8'hEE;

  always @(posedge clk) begin
    if (ram_reads && !$isunknown(ram_addr)) rd_cnt <= rd_cnt + 1;
    else rd_cnt <= 0;
  end

  always @(negedge clk) begin
    if (selected && !ram_wr_n && ram_dq_oe) mem[ram_addr] = ram_dq_out;
    if (ram_reads && ram_dq_oe) begin
      checks++; fails++;
      $display("FAIL R5 bus contention: dq_oe=%0b rd_en_n=%0b expected no drive", ram_dq_oe, ram_rd_en_n);
    end
  end

  // ---------------- reference model ----------------
  function automatic exp_t mk(input logic [7:0] c, input logic ca, input logic [12:0] a,
                              input logic cd, input logic [7:0] d, input string t);
    exp_t e;
    e.ctl = c; e.chk_addr = ca; e.addr = a; e.chk_dq = cd; e.data = d; e.tag = t;
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst_n && req_valid && exp_q.size() == 0) begin
      if (req_write) begin
        for (int i = 0; i < WP_C; i++)
          exp_q.push_back(mk(8'b0110_1000, 1, req_addr, 1, req_wdata, "R6"));
        for (int i = 0; i < WREC_C; i++)
          exp_q.push_back(mk(8'b1011_0000, 0, '0, 0, '0, "R7"));
        exp_q.push_back(mk(8'b1011_0101, 0, '0, 0, '0, "R7"));
        shadow[req_addr] = req_wdata;
      end else begin
        for (int i = 0; i < RD_C; i++)
          exp_q.push_back(mk(8'b0101_0000, 1, req_addr, 0, '0, "R3"));
        exp_q.push_back(mk(8'b1011_0010, 0, '0, 1, shadow[req_addr], "R4"));
        for (int i = 1; i < HZ_C; i++)
          exp_q.push_back(mk(8'b1011_0000, 0, '0, 0, '0, "R5"));
        exp_q.push_back(mk(8'b1011_0100, 0, '0, 0, '0, "R5"));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t e;
      logic [7:0] act;
      logic ok;
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else e = mk(8'b1011_0100, 0, '0, 0, '0, "R2");
      act = {ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_n, ram_dq_oe, ready, rd_valid, wr_done};
      ok = (act == e.ctl);
      if (e.chk_addr && ram_addr != e.addr) ok = 0;
      if (e.chk_dq && e.ctl[1] && rd_data != e.data) ok = 0;
      if (e.chk_dq && e.ctl[3] && ram_dq_out != e.data) ok = 0;
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: ctl=%b addr=%h rd=%h dq=%h expected ctl=%b addr=%h data=%h",
                 e.tag, act, ram_addr, rd_data, ram_dq_out, e.ctl, e.addr, e.data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic w, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem[i] = 8'((i * 7) ^ (i >> 5));
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: state under reset
    checks++;
    if ({ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_n, ram_dq_oe, ready, rd_valid, wr_done} != 8'b1011_0100) begin
      fails++;
      $display("FAIL R1 reset: got %b expected 10110100",
               {ram_sel_n, ram_sel, ram_rd_en_n, ram_wr_n, ram_dq_oe, ready, rd_valid, wr_done});
    end
    #1 rst_n = 1;
    repeat (5) @(negedge clk);   // R1: idle after release is compared by the model

    // R10: write patterns at edges and middle, read back
    issue(1, 13'h0000, 8'h00);
    issue(1, 13'h1FFF, 8'hFF);
    issue(1, 13'h1555, 8'hA5);
    issue(0, 13'h0000, 8'h00);
    issue(0, 13'h1FFF, 8'h00);
    issue(0, 13'h1555, 8'h00);
    // R3/R4: never-written address returns preset contents
    issue(0, 13'h0ABC, 8'h00);

    // R2: requests while busy are ignored
    issue(0, 13'h0005, 8'h00);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 13'h0005; req_wdata = 8'h3C;
    repeat (4) @(negedge clk);
    #1 req_valid = 0;
    drain();
    issue(0, 13'h0005, 8'h00);   // R2: original byte must come back

    // R7/R10: write then read back to back, overwrite
    issue(1, 13'h0100, 8'h5A);
    issue(0, 13'h0100, 8'h00);
    issue(1, 13'h0100, 8'hC3);
    issue(0, 13'h0100, 8'h00);
    drain();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule